// File: doc/BRIEF.md
# Register-Controlled LED Running Light

This block animates an 8-bit pattern that drives eight LED outputs directly. A small memory-mapped register set selects how the pattern moves, holds the current pattern, and sets how long each step is held. The pattern moves one step each time a pause counter runs out. The moves are rotate toward bit 7, rotate toward bit 0, a bounce in which the single odd bit travels back and forth between the two ends, and a hold setting that freezes the light.

Software reaches the registers through a simple request/response bus. A request carries an address, a write enable and write data, and it is accepted when both valid and ready are high. Exactly one cycle after acceptance, a registered response returns with a valid flag and read data. Reading the pattern register returns the live state of the light, so software can follow the animation.

Top module: `led_chaser`

## Requirements
- R1: After a synchronous active-low reset, the LEDs show 0x01, the mode register reads 1 (rotate toward bit 0), and the delay register reads 0.
- R2: With delay value d, the pattern changes exactly once every d+1 clock cycles. A value of 0 steps it on every cycle.
- R3: Mode 0 rotates the pattern one place toward bit 7 with wrap-around (bit 7 goes to bit 0). Mode 1 rotates it one place toward bit 0 with wrap-around. The number of lit bits is preserved.
- R4: Mode 2 bounces the odd bit. The odd bit is the single set bit when four or fewer bits are lit, and otherwise the single clear bit. It moves one place per step and reverses on reaching bit 7 or bit 0, so it never wraps. After reset, the bounce direction is toward bit 7.
- R5: Mode 3 holds the pattern unchanged.
- R6: A write to the pattern register (offset 0x4, data bits 7:0) loads the pattern at the accepting edge. This takes priority over a step in the same cycle, and animation continues from the loaded value.
- R7: A write to the delay register (offset 0x8) reloads the pause counter, so the next step happens exactly d+1 cycles after the accepting edge.
- R8: A read of offset 0x4 returns the live pattern as it stood in the cycle the request was accepted. Reads of offset 0x0 return the mode in bits 1:0, and reads of offset 0x8 return the delay.
- R9: Reads of any other offset return zero. Writes to any other offset change no register. Write responses carry zero read data.
- R10: A response is valid exactly one cycle after acceptance. Ready is low during that response cycle, so at most one request is outstanding, and a request held valid is accepted at most every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W (4) | Byte offset of the register |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata | output | DATA_W (32) | Registered read data |
| led | output | 8 | Pattern driving the LEDs |

## Verification
The bench measures the interval between pattern changes, rather than merely watching the pattern change, so a pause counter that is off by one or that fails to reload on a delay write gives an interval of d or d+2 cycles. The bounce test starts from both a single lit bit and a single dark bit and runs past both ends, so a design that wraps, or that follows the wrong bit, shows a value out of sequence. Pattern writes are made while the light steps every cycle, to catch a step that wins over the load. Reads are taken while the pattern is moving, to catch read data sampled one cycle late. Unmapped writes, and a request held valid for several cycles, expose stray decode and a second outstanding request.

// File: rtl/led_chaser_pkg.sv
package led_chaser_pkg;

  localparam int PAT_W = 8;

  typedef enum logic [1:0] {
    MODE_LEFT   = 2'd0,
    MODE_RIGHT  = 2'd1,
    MODE_BOUNCE = 2'd2,
    MODE_HOLD   = 2'd3
  } run_mode_e;

  // one place toward the MSB, MSB wraps into bit 0
  function automatic logic [PAT_W-1:0] rot_up(input logic [PAT_W-1:0] p);
    return {p[PAT_W-2:0], p[PAT_W-1]};
  endfunction

  // one place toward bit 0, bit 0 wraps into the MSB
  function automatic logic [PAT_W-1:0] rot_down(input logic [PAT_W-1:0] p);
    return {p[0], p[PAT_W-1:1]};
  endfunction

  // pattern in which the odd bit is the one that is set
  function automatic logic [PAT_W-1:0] odd_view(input logic [PAT_W-1:0] p);
    return ($countones(p) > PAT_W / 2) ? ~p : p;
  endfunction

  // bounce direction for the coming step (1 = toward MSB)
  function automatic logic bounce_dir(input logic [PAT_W-1:0] p, input logic going_up);
    logic [PAT_W-1:0] v;
    v = odd_view(p);
    if (going_up && v[PAT_W-1]) return 1'b0;
    if (!going_up && v[0])      return 1'b1;
    return going_up;
  endfunction

endpackage

// File: rtl/led_pause_timer.sv
module led_pause_timer #(
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reload_en,
  input  logic [DELAY_W-1:0] reload_val,
  input  logic [DELAY_W-1:0] delay_q,
  output logic               step
);

  logic [DELAY_W-1:0] cnt_q;

  assign step = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (reload_en) cnt_q <= reload_val;
    else if (step)      cnt_q <= delay_q;
    else                cnt_q <= cnt_q - 1'b1;
  end

  AST_CNT_WITHIN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= delay_q); // R2

endmodule

// File: rtl/led_pattern_step.sv
module led_pattern_step
  import led_chaser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  run_mode_e        mode,
  input  logic             step,
  input  logic             load_en,
  input  logic [PAT_W-1:0] load_val,
  output logic [PAT_W-1:0] pattern
);

  logic             up_q;
  logic             up_next;
  logic [PAT_W-1:0] stepped;

  assign up_next = bounce_dir(pattern, up_q);

  always_comb begin
    unique case (mode)
      MODE_LEFT:   stepped = rot_up(pattern);
      MODE_RIGHT:  stepped = rot_down(pattern);
      MODE_BOUNCE: stepped = up_next ? rot_up(pattern) : rot_down(pattern);
      default:     stepped = pattern;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pattern <= PAT_W'(1);
      up_q    <= 1'b1;
    end else if (load_en) begin
      pattern <= load_val;
    end else if (step) begin
      pattern <= stepped;
      if (mode == MODE_BOUNCE) up_q <= up_next;
    end
  end

  AST_ONES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $countones(pattern) == $countones($past(pattern))); // R3

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD && !load_en) |=> $stable(pattern)); // R5

endmodule

// File: rtl/led_bus_regs.sv
module led_bus_regs
  import led_chaser_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_we,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic [PAT_W-1:0]   pattern,
  output run_mode_e          mode_q,
  output logic [DELAY_W-1:0] delay_q,
  output logic               pat_wr,
  output logic               delay_wr
);

  localparam logic [ADDR_W-1:0] OFF_MODE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_PAT   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_DELAY = ADDR_W'(8);

  logic              accept;
  logic              hit_mode, hit_pat, hit_delay, hit_none;
  logic              mode_wr;
  logic              stray_wr;
  logic              stray_rd;
  logic [DATA_W-1:0] rd_mux;

  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;

  assign hit_mode  = (req_addr == OFF_MODE);
  assign hit_pat   = (req_addr == OFF_PAT);
  assign hit_delay = (req_addr == OFF_DELAY);
  assign hit_none  = !(hit_mode || hit_pat || hit_delay);

  assign mode_wr   = accept && req_we && hit_mode;
  assign pat_wr    = accept && req_we && hit_pat;
  assign delay_wr  = accept && req_we && hit_delay;
  assign stray_wr  = accept && req_we && hit_none;
  assign stray_rd  = accept && !req_we && hit_none;

  always_comb begin
    rd_mux = '0;
    if (hit_mode)  rd_mux = DATA_W'(mode_q);
    if (hit_pat)   rd_mux = DATA_W'(pattern);
    if (hit_delay) rd_mux = DATA_W'(delay_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_RIGHT;
      delay_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (mode_wr)  mode_q  <= run_mode_e'(req_wdata[1:0]);
      if (delay_wr) delay_q <= req_wdata[DELAY_W-1:0];
      rsp_valid <= accept;
      rsp_rdata <= (accept && !req_we) ? rd_mux : '0;
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10

  AST_STRAY_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    stray_wr |=> $stable(mode_q) && $stable(delay_q)); // R9

  AST_STRAY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stray_rd |=> rsp_valid && rsp_rdata == '0); // R9

endmodule

// File: rtl/led_chaser.sv
module led_chaser
  import led_chaser_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int DELAY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [PAT_W-1:0]  led
);

  run_mode_e          mode_q;
  logic [DELAY_W-1:0] delay_q;
  logic               pat_wr;
  logic               delay_wr;
  logic               step;

  led_bus_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DELAY_W(DELAY_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .req_we   (req_we),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .pattern  (led),
    .mode_q   (mode_q),
    .delay_q  (delay_q),
    .pat_wr   (pat_wr),
    .delay_wr (delay_wr)
  );

  led_pause_timer #(
    .DELAY_W(DELAY_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .reload_en (delay_wr),
    .reload_val(req_wdata[DELAY_W-1:0]),
    .delay_q   (delay_q),
    .step      (step)
  );

  led_pattern_step u_pattern (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .step    (step),
    .load_en (pat_wr),
    .load_val(req_wdata[PAT_W-1:0]),
    .pattern (led)
  );

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pat_wr |=> led == $past(req_wdata[PAT_W-1:0])); // R6

endmodule

// File: tb/tb_led_chaser.sv
module tb_led_chaser;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_addr = '0;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0]  led;

  int n_checks = 0;
  int n_err    = 0;
  bit tb_up    = 1'b1;
  bit done     = 1'b0;

  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  led_chaser dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .led(led)
  );

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_exp.size() == 0) begin
        n_checks++;
        n_err++;
        $display("FAIL R10 unexpected response actual=%0h expected=none", rsp_rdata);
      end else begin
        check_eq(q_tag.pop_front(), rsp_rdata, q_exp.pop_front());
      end
    end
  end

  // driver: returns at the negedge right after the accepting edge
  task automatic bus_op(input logic [3:0] a, input bit we, input logic [31:0] d,
                        input logic [31:0] exp, input bit live_pat, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = d;
    q_exp.push_back(live_pat ? 32'(led) : exp);
    q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    check_eq("R10 ready low in response cycle", 32'(req_ready), 32'd0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_op(a, 1'b1, d, 32'd0, 1'b0, "R9 write response data");
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_op(a, 1'b0, 32'd0, exp, 1'b0, tag);
  endtask

  task automatic model_step(input logic [7:0] p, input int m, output logic [7:0] n);
    int   ones;
    int   pos;
    logic [7:0] v;
    case (m)
      0: n = {p[6:0], p[7]};
      1: n = {p[0], p[7:1]};
      2: begin
        ones = $countones(p);
        v = (ones > 4) ? ~p : p;
        pos = 0;
        for (int i = 0; i < 8; i++) if (v[i]) pos = i;
        if (tb_up && pos == 7) tb_up = 1'b0;
        else if (!tb_up && pos == 0) tb_up = 1'b1;
        n = tb_up ? {p[6:0], p[7]} : {p[0], p[7:1]};
      end
      default: n = p;
    endcase
  endtask

  // follow the light: sync on a change, then check interval and value of each step
  task automatic run_check(input string tag, input int period, input int nsteps, input int m);
    logic [7:0] prev;
    logic [7:0] exp;
    int cnt;
    prev = led;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (led == prev && cnt < period + 3);
    model_step(prev, m, exp);
    check_eq({tag, " value"}, 32'(led), 32'(exp));
    prev = led;
    for (int k = 0; k < nsteps; k++) begin
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (led == prev && cnt < period + 3);
      check_eq("R2 step interval", cnt, period);
      model_step(prev, m, exp);
      check_eq({tag, " value"}, 32'(led), 32'(exp));
      prev = led;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1 reset pattern", 32'(led), 32'h01);
    rst_n = 1'b1;
    tb_up = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] base;
    int cnt;
    repeat (3) @(negedge clk);
    check_eq("R1 reset pattern", 32'(led), 32'h01);
    rst_n = 1'b1;

    // default: rotate toward bit 0, every cycle
    run_check("R3 right d0", 1, 4, 1);
    rd(4'h0, 32'd1, "R1 mode after reset");
    rd(4'h8, 32'd0, "R1 delay after reset");
    bus_op(4'h4, 1'b0, 0, 0, 1'b1, "R8 live pattern read");

    // hold
    wr(4'h0, 32'd3);
    base = led;
    repeat (5) begin @(negedge clk); check_eq("R5 hold keeps pattern", 32'(led), 32'(base)); end

    // load and rotate toward bit 0 with pause 1
    wr(4'h4, 32'hFE);
    check_eq("R6 pattern load", 32'(led), 32'hFE);
    wr(4'h8, 32'd1);
    wr(4'h0, 32'd1);
    run_check("R3 right d1", 2, 9, 1);

    // delay change while running
    wr(4'h8, 32'h42);
    base = led;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (led == base && cnt < 80);
    check_eq("R7 first step after delay write", cnt, 67);
    run_check("R3 right d66", 67, 1, 1);
    rd(4'h8, 32'h42, "R8 delay readback");

    // rotate toward bit 7
    wr(4'h8, 32'd2);
    wr(4'h0, 32'd0);
    run_check("R3 left d2", 3, 10, 0);

    // load priority over an every-cycle step
    wr(4'h8, 32'd0);
    wr(4'h4, 32'hA5);
    check_eq("R6 load beats step", 32'(led), 32'hA5);
    @(negedge clk);
    check_eq("R6 continues from loaded value", 32'(led), 32'h4B);
    bus_op(4'h4, 1'b0, 0, 0, 1'b1, "R8 live pattern read moving");

    // unmapped offsets
    wr(4'h0, 32'd3);
    base = led;
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, 32'd0, "R9 unmapped read");
    rd(4'h1, 32'd0, "R9 misaligned read");
    rd(4'h0, 32'd3, "R9 mode unchanged");
    rd(4'h8, 32'd0, "R9 delay unchanged");
    check_eq("R9 pattern unchanged", 32'(led), 32'(base));

    // request held valid: accepted every other cycle
    @(negedge clk);
    req_valid = 1'b1; req_addr = 4'h0; req_we = 1'b0;
    q_exp.push_back(32'd3); q_tag.push_back("R10 held request 1");
    q_exp.push_back(32'd3); q_tag.push_back("R10 held request 2");
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R10 all responses seen", q_exp.size(), 0);

    // bounce with a single lit bit
    do_reset();
    wr(4'h0, 32'd3);
    wr(4'h4, 32'h80);
    wr(4'h8, 32'd0);
    wr(4'h0, 32'd2);
    run_check("R4 bounce lit", 1, 20, 2);

    // bounce with a single dark bit
    do_reset();
    wr(4'h0, 32'd3);
    wr(4'h4, 32'hFE);
    wr(4'h8, 32'd0);
    wr(4'h0, 32'd2);
    run_check("R4 bounce dark", 1, 16, 2);

    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule